// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This controller moves a small processor between normal running and two low-power modes, wait and stop, and decides when the processor may come out of them. It watches 23 interrupt request lines. Each line has its own priority. The controller also sees the current processor priority level, the global interrupt-enable flag and a few per-peripheral qualifiers: a clock-synchronous serial channel running on an external clock, a timer counting an external event, and the converter in one-shot mode. A hardware reset also ends either mode.

The controller holds the bus-clock configuration register. This register has the clock source select, the divide-by-8 select, a two-bit divider, the low-speed select, and a drive-strength bit for each oscillator. Software writes the register while running. The controller freezes it during a low-power mode. On entry to stop mode it forces divide-by-8, but only when the main clock was driving the bus. When the processor wakes, the controller reports which source woke it.

There is no data stream through this block, so it has no valid/ready interface. All pins are plain control and status levels or one-cycle pulses. The wake report is a single-cycle pulse with no back-pressure. The interrupt sequencer that consumes it must capture it in the cycle it appears.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the outputs are as follows until the next edge that changes them: `mode` = 0 (run), `clk_cfg` = 0x68 and `wake_valid` = 0. The `clk_cfg` bit layout is 6 = main drive high, 5 = subclock drive high, 4 = subclock selected, 3 = divide-by-8, 2:1 = divider, 0 = low-speed.
- R2: The mode codes are run = 0, wait = 1 and stop = 2. In run mode, `enter_stop` moves to stop at the next edge. Otherwise `enter_wait` moves to wait. Both requests are ignored in wait and stop.
- R3: In run mode with neither entry request high, `cfg_we` loads `cfg_wdata`, using the R1 layout, into `clk_cfg` at the next edge. A write in the same cycle as an entry request is ignored. A write in wait or stop is also ignored.
- R4: A request can wake the processor only if two things hold in that cycle: its 3-bit priority field is strictly greater than `ipl`, and `ien` = 1.
- R5: A qualifying request in wait or stop returns `mode` to run at the next edge. In that same edge `wake_valid` goes high for exactly one cycle and `wake_src` holds the source index. `wake_valid` never rises from run mode.
- R6: On leaving wait mode, `clk_cfg` equals its value from before entry.
- R7: On entry to stop with bit 4 = 0, bit 3 becomes 1 and all other bits keep their values. On entry to stop with bit 4 = 1, nothing changes.
- R8: The source indices are: 0 and 1 for DMA, 2 for the converter, 3 to 6 for serial tx0, rx0, tx1 and rx1, 7 for serial auto-transfer, 8 for display, 9 to 16 for timers 0 to 7, and 17 to 22 for external INT0 to INT5. In wait mode with `pclk_stop` = 0, every source can wake except 0 and 1. Source 2 wakes only when `ad_oneshot` = 1.
- R9: In stop mode, or in wait mode with `pclk_stop` = 1, sources 0, 1, 2, 7 and 8 never wake. Sources 3 and 4 wake only when `uart_ext[0]` = 1, and sources 5 and 6 only when `uart_ext[1]` = 1. Source 9+k wakes only when `tmr_event[k]` = 1.
- R10: Sources 17 to 22 can wake in every low-power mode, subject only to R4.
- R11: Among simultaneous qualifying requests, the one with the highest priority is reported. A tie goes to the lower index.
- R12: A reset during wait or stop returns the block to run mode with the R1 configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| enter_wait | input | 1 | Request to enter wait mode |
| enter_stop | input | 1 | Request to enter stop mode |
| cfg_we | input | 1 | Clock configuration write strobe |
| cfg_wdata | input | 7 | Clock configuration write value |
| pclk_stop | input | 1 | Peripheral clock stopped during wait |
| irq_req | input | 23 | Interrupt request lines |
| irq_prio | input | 69 | 3-bit priority per source, source i at bits 3i+2:3i |
| ipl | input | 3 | Current processor priority level |
| ien | input | 1 | Global interrupt enable |
| uart_ext | input | 2 | Serial channel uses an external clock in synchronous mode |
| tmr_event | input | 8 | Timer counts an external event |
| ad_oneshot | input | 1 | Converter in one-shot or one-shot-sweep mode |
| mode | output | 2 | Current mode code |
| clk_cfg | output | 7 | Bus clock configuration |
| wake_valid | output | 1 | One-cycle wake report |
| wake_src | output | 5 | Index of the waking source |

## Verification
Every result is registered. A mode change, a configuration load, the stop-entry divide-by-8 force and the wake report all appear one rising edge after the inputs that cause them, and a reset acts immediately. The bench drives inputs on the falling edge and advances its behavioural model from those inputs. At the next falling edge it compares `mode`, `clk_cfg` and `wake_valid` against the model. It compares `wake_src` only in cycles where the model expects a wake. This way every comparison lands exactly one edge after its stimulus.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int NSRC      = 23;
  localparam int SRC_W     = $clog2(NSRC);
  localparam int N_UART_CH = 2;
  localparam int N_TMR     = 8;
  localparam int N_EXT     = 6;
  localparam int CFG_W     = 7;

  localparam int S_AD      = 2;
  localparam int UART_BASE = 3;
  localparam int S_SIO     = UART_BASE + 2 * N_UART_CH;
  localparam int S_DISP    = S_SIO + 1;
  localparam int TMR_BASE  = S_DISP + 1;
  localparam int EXT_BASE  = TMR_BASE + N_TMR;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_STOP = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    K_DMA, K_AD, K_GATED, K_UART, K_TMR, K_EXT
  } kind_e;

  typedef struct packed {
    logic       main_drv;
    logic       sub_drv;
    logic       sel_sub;
    logic       div8;
    logic [1:0] div;
    logic       low_spd;
  } clk_cfg_t;

  localparam clk_cfg_t CFG_RESET = '{main_drv: 1'b1, sub_drv: 1'b1,
                                     sel_sub: 1'b0, div8: 1'b1,
                                     div: 2'b00, low_spd: 1'b0};

  function automatic kind_e src_kind(input int idx);
    if (idx < S_AD)                            return K_DMA;
    else if (idx == S_AD)                      return K_AD;
    else if (idx < S_SIO)                      return K_UART;
    else if (idx <= S_DISP)                    return K_GATED;
    else if (idx < EXT_BASE)                   return K_TMR;
    else                                       return K_EXT;
  endfunction
endpackage

// File: rtl/lpm_wake_qualify.sv
module lpm_wake_qualify
  import lpm_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  mode_e                    mode,
  input  logic                     pclk_stop,
  input  logic [NSRC-1:0]          irq_req,
  input  logic [NSRC*PRIO_W-1:0]   irq_prio,
  input  logic [PRIO_W-1:0]        ipl,
  input  logic                     ien,
  input  logic [N_UART_CH-1:0]     uart_ext,
  input  logic [N_TMR-1:0]         tmr_event,
  input  logic                     ad_oneshot,
  output logic [NSRC-1:0]          elig
);
  logic lp_active;
  logic restricted;

  assign lp_active  = (mode != MODE_RUN);
  assign restricted = (mode == MODE_STOP) | pclk_stop;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam kind_e K = src_kind(g);
    logic base_ok;
    logic allow;

    assign base_ok = irq_req[g] & ien & (irq_prio[g*PRIO_W +: PRIO_W] > ipl);

    if (K == K_DMA) begin : g_dma
      assign allow = 1'b0;
    end else if (K == K_AD) begin : g_ad
      assign allow = ~restricted & ad_oneshot;
    end else if (K == K_GATED) begin : g_gated
      assign allow = ~restricted;
    end else if (K == K_UART) begin : g_uart
      assign allow = ~restricted | uart_ext[(g - UART_BASE) / 2];
    end else if (K == K_TMR) begin : g_tmr
      assign allow = ~restricted | tmr_event[g - TMR_BASE];
    end else begin : g_ext
      assign allow = 1'b1;
    end

    assign elig[g] = base_ok & allow & lp_active;
  end
endmodule

// File: rtl/lpm_wake_arb.sv
module lpm_wake_arb
  import lpm_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic [NSRC-1:0]        elig,
  input  logic [NSRC*PRIO_W-1:0] irq_prio,
  output logic                   any,
  output logic [SRC_W-1:0]       best
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    any    = 1'b0;
    best   = '0;
    best_p = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!any || irq_prio[i*PRIO_W +: PRIO_W] > best_p)) begin
        any    = 1'b1;
        best   = SRC_W'(i);
        best_p = irq_prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/lpm_clk_cfg.sv
module lpm_clk_cfg
  import lpm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  clk_cfg_t wdata,
  input  logic     stop_entry,
  input  logic     hold,
  output clk_cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (stop_entry) begin
      if (!cfg_q.sel_sub) cfg_q.div8 <= 1'b1;
    end else if (wr_en) begin
      cfg_q <= wdata;
    end
  end

  a_r7_main_forces_div8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_entry && !cfg_q.sel_sub) |=> (cfg_q.div8 && !cfg_q.sel_sub &&
      cfg_q.div == $past(cfg_q.div) && cfg_q.low_spd == $past(cfg_q.low_spd) &&
      cfg_q.main_drv == $past(cfg_q.main_drv) && cfg_q.sub_drv == $past(cfg_q.sub_drv)));

  a_r7_sub_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_entry && cfg_q.sel_sub) |=> $stable(cfg_q));

  a_r6_frozen_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cfg_q));
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
  import lpm_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enter_wait,
  input  logic                   enter_stop,
  input  logic                   cfg_we,
  input  logic [CFG_W-1:0]       cfg_wdata,
  input  logic                   pclk_stop,
  input  logic [NSRC-1:0]        irq_req,
  input  logic [NSRC*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]      ipl,
  input  logic                   ien,
  input  logic [N_UART_CH-1:0]   uart_ext,
  input  logic [N_TMR-1:0]       tmr_event,
  input  logic                   ad_oneshot,
  output logic [1:0]             mode,
  output logic [CFG_W-1:0]       clk_cfg,
  output logic                   wake_valid,
  output logic [SRC_W-1:0]       wake_src
);
  mode_e            mode_q;
  logic [NSRC-1:0]  elig;
  logic             wake_any;
  logic [SRC_W-1:0] wake_best;
  logic             in_run;
  logic             stop_entry;
  logic             cfg_wr;
  clk_cfg_t         cfg_q;

  assign in_run     = (mode_q == MODE_RUN);
  assign stop_entry = in_run & enter_stop;
  assign cfg_wr     = in_run & cfg_we & ~enter_stop & ~enter_wait;

  lpm_wake_qualify #(.PRIO_W(PRIO_W)) u_qual (
    .mode(mode_q), .pclk_stop(pclk_stop), .irq_req(irq_req), .irq_prio(irq_prio),
    .ipl(ipl), .ien(ien), .uart_ext(uart_ext), .tmr_event(tmr_event),
    .ad_oneshot(ad_oneshot), .elig(elig)
  );

  lpm_wake_arb #(.PRIO_W(PRIO_W)) u_arb (
    .elig(elig), .irq_prio(irq_prio), .any(wake_any), .best(wake_best)
  );

  lpm_clk_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(clk_cfg_t'(cfg_wdata)),
    .stop_entry(stop_entry), .hold(~in_run), .cfg_q(cfg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_RUN;
      wake_valid <= 1'b0;
      wake_src   <= '0;
    end else begin
      wake_valid <= 1'b0;
      if (in_run) begin
        if (enter_stop)      mode_q <= MODE_STOP;
        else if (enter_wait) mode_q <= MODE_WAIT;
      end else if (wake_any) begin
        mode_q     <= MODE_RUN;
        wake_valid <= 1'b1;
        wake_src   <= wake_best;
      end
    end
  end

  assign mode    = mode_q;
  assign clk_cfg = cfg_q;

  a_r2_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  a_r5_wake_leaves_lp: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (mode_q == MODE_RUN && $past(mode_q) != MODE_RUN));

  a_r5_no_wake_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |=> !wake_valid);

  a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> $past(ien));

  a_r11_src_requested: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> ((($past(irq_req) >> wake_src) & NSRC'(1)) != '0));

  a_r8_no_dma_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (wake_src > SRC_W'(1)));

  a_r9_stop_blocks_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && $past(mode_q) == MODE_STOP) |->
      !(wake_src inside {SRC_W'(S_AD), SRC_W'(S_SIO), SRC_W'(S_DISP)}));
endmodule

// File: tb/sim_lpm_wake_ctrl.sv
module sim_lpm_wake_ctrl;
  localparam int PER = 10;
  localparam int NS  = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter_wait = 0, enter_stop = 0, cfg_we = 0, pclk_stop = 0, ien = 1, ad_oneshot = 0;
  logic [6:0] cfg_wdata = '0;
  logic [NS-1:0] irq_req = '0;
  logic [NS*3-1:0] irq_prio = '0;
  logic [2:0] ipl = '0;
  logic [1:0] uart_ext = '0;
  logic [7:0] tmr_event = '0;
  logic [1:0] mode;
  logic [6:0] clk_cfg;
  logic wake_valid;
  logic [4:0] wake_src;

  int checks = 0, bad = 0;
  bit done = 0;
  string tag = "R1";
  int m_mode = 0, m_wv = 0, m_src = 0;
  logic [6:0] m_cfg = 7'h68;

  lpm_wake_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .enter_wait(enter_wait), .enter_stop(enter_stop),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .pclk_stop(pclk_stop), .irq_req(irq_req),
    .irq_prio(irq_prio), .ipl(ipl), .ien(ien), .uart_ext(uart_ext),
    .tmr_event(tmr_event), .ad_oneshot(ad_oneshot), .mode(mode), .clk_cfg(clk_cfg),
    .wake_valid(wake_valid), .wake_src(wake_src)
  );

  always #(PER/2) clk = ~clk;

  function automatic int prio_of(int i);
    return int'(irq_prio[i*3 +: 3]);
  endfunction

  function automatic bit can_wake(int i);
    bit limited;
    if (!irq_req[i] || !ien || prio_of(i) <= int'(ipl)) return 0;
    if (i >= 17) return 1;
    if (i <= 1) return 0;
    limited = (m_mode == 2) || pclk_stop;
    if (!limited) return (i == 2) ? ad_oneshot : 1'b1;
    if (i >= 3 && i <= 6) return uart_ext[(i-3)/2];
    if (i >= 9 && i <= 16) return tmr_event[i-9];
    return 0;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    int best;
    if (!rst_n) begin
      m_mode = 0; m_cfg = 7'h68; m_wv = 0;
    end else if (m_mode == 0) begin
      m_wv = 0;
      if (enter_stop) begin
        m_mode = 2;
        if (!m_cfg[4]) m_cfg[3] = 1'b1;
      end else if (enter_wait) m_mode = 1;
      else if (cfg_we) m_cfg = cfg_wdata;
    end else begin
      best = -1;
      for (int i = 0; i < NS; i++)
        if (can_wake(i) && (best < 0 || prio_of(i) > prio_of(best))) best = i;
      if (best >= 0) begin
        m_mode = 0; m_wv = 1; m_src = best;
      end else m_wv = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check(int'(mode) == m_mode, "mode", int'(mode), m_mode);
    check(clk_cfg == m_cfg, "clk_cfg", int'(clk_cfg), int'(m_cfg));
    check(int'(wake_valid) == m_wv, "wake_valid", int'(wake_valid), m_wv);
    if (m_wv != 0) check(int'(wake_src) == m_src, "wake_src", int'(wake_src), m_src);
  endtask

  task automatic idle();
    enter_wait = 0; enter_stop = 0; cfg_we = 0; irq_req = '0;
  endtask

  task automatic go_wait(bit pstop);
    idle(); pclk_stop = pstop; enter_wait = 1; cyc(); enter_wait = 0;
  endtask

  task automatic go_stop();
    idle(); enter_stop = 1; cyc(); enter_stop = 0;
  endtask

  task automatic req(int i);
    irq_req = '0; irq_req[i] = 1'b1; cyc(); irq_req = '0;
  endtask

  task automatic set_cfg(logic [6:0] v);
    idle(); cfg_we = 1; cfg_wdata = v; cyc(); cfg_we = 0;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) irq_prio[i*3 +: 3] = 3'd1;
    @(negedge clk);
    tag = "R1"; cyc(); cyc();
    rst_n = 1; cyc();

    tag = "R3"; set_cfg(7'h55); cyc();
    cfg_we = 1; cfg_wdata = 7'h11; enter_wait = 1; cyc(); idle();
    cfg_we = 1; cfg_wdata = 7'h22; cyc(); idle();

    tag = "R2"; enter_stop = 1; cyc(); idle(); cyc();
    tag = "R10"; req(17);
    tag = "R6"; set_cfg(7'h12); go_wait(0); cyc(); req(20); cyc();

    tag = "R4"; go_wait(0);
    irq_prio[17*3 +: 3] = 3'd3; ipl = 3'd3; req(17);
    irq_prio[17*3 +: 3] = 3'd4; ien = 0; req(17);
    ien = 1; req(17); ipl = 0;

    tag = "R7"; set_cfg(7'h44); go_stop(); req(18);
    set_cfg(7'h35); go_stop(); req(19);

    tag = "R8"; go_wait(0); req(0); req(1); ad_oneshot = 0; req(2);
    ad_oneshot = 1; req(2); go_wait(0); req(7); go_wait(0); req(12);

    tag = "R9"; go_stop(); req(7); req(8); req(2); uart_ext = 2'b10; req(3);
    uart_ext = 2'b01; req(4); req(9); tmr_event = 8'h01; req(9);
    go_wait(1); req(8); uart_ext = 0; req(5); tmr_event = 8'h80; req(16);
    tmr_event = 0;

    tag = "R10"; go_stop(); req(22); go_wait(1); req(21);

    tag = "R11"; go_wait(0);
    irq_prio[17*3 +: 3] = 3'd5; irq_prio[18*3 +: 3] = 3'd6; irq_prio[19*3 +: 3] = 3'd6;
    irq_req = '0; irq_req[17] = 1; irq_req[18] = 1; irq_req[19] = 1; cyc(); idle();
    go_stop(); irq_req[12] = 1; irq_req[20] = 1; tmr_event = 8'h08; cyc(); idle();
    tmr_event = 0;

    tag = "R12"; set_cfg(7'h04); go_stop(); rst_n = 0; cyc(); rst_n = 1; cyc();
    go_wait(1); rst_n = 0; cyc(); rst_n = 1; cyc();

    tag = "R5";
    for (int n = 0; n < 4000; n++) begin
      irq_req    = NS'($urandom & $urandom & $urandom);
      for (int i = 0; i < NS; i++) irq_prio[i*3 +: 3] = 3'($urandom);
      ipl        = 3'($urandom);
      ien        = ($urandom % 4) != 0;
      enter_wait = ($urandom % 4) == 0;
      enter_stop = ($urandom % 4) == 0;
      cfg_we     = ($urandom % 3) == 0;
      cfg_wdata  = 7'($urandom);
      pclk_stop  = 1'($urandom);
      uart_ext   = 2'($urandom);
      tmr_event  = 8'($urandom);
      ad_oneshot = 1'($urandom);
      rst_n      = ($urandom % 500) != 0;
      cyc();
    end
    rst_n = 1;
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(PER * 150000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL %s watchdog act=0 exp=1", tag);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule